// File: doc/BRIEF.md
# SIMD Lane-Wise Integer Compare Unit

This block compares two vector operands lane by lane and returns a per-lane mask: every lane whose condition holds becomes all ones across its element width, every other lane becomes zero. A size code picks the element width (8, 16, 32 or 64 bits), a condition code picks one of seven signed or unsigned relations, and a width flag selects a 64-bit or a 128-bit register view. In the 64-bit view only the low half is compared and the upper half of the result is forced to zero. A zero-operand flag replaces the second operand of every lane with zero.

Operands enter through a valid/ready stream and the mask leaves through a second valid/ready stream after a single register stage. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. When the consumer holds `out_ready` low, the result stays in place and no new request is taken. A request with an unsupported encoding produces no result. Instead it raises a one-cycle error pulse.

Top module: `vec_lane_cmp`

## Requirements
- R1: The element width is 8 << `in_size` bits (size codes 0..3). Lane k takes bits [k*W+W-1 : k*W] of each operand. The number of compared lanes is the register byte count (16 when `in_wide`=1, 8 when `in_wide`=0) shifted right by the size code.
- R2: Each compared lane of `out_data` is all ones when its condition holds and all zeros when it fails.
- R3: Condition codes on `in_cond` are: 0 equal, 1 signed greater-or-equal, 2 signed greater-than, 5 signed less-or-equal, 6 signed less-than. Signed conditions sign-extend both lanes before comparing.
- R4: Codes 3 (unsigned greater-than) and 4 (unsigned greater-or-equal) compare the lanes as zero-extended values.
- R5: When `in_zero_b`=1, `in_b` is ignored and the second operand of every lane is zero.
- R6: When `in_wide`=0, bits 127:64 of `out_data` are zero.
- R7: A taken request is illegal when `in_cond`=7, or when `in_size`=3 with `in_wide`=0. An illegal request sets `err_illegal` high for exactly the next cycle, leaves `out_valid` low and leaves `out_data` unchanged.
- R8: A request is taken when `in_valid`=1 and `in_ready`=1. `in_ready` = !`out_valid` || `out_ready`. A legal taken request raises `out_valid` on the next cycle.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold their values.
- R10: After reset, `out_valid`, `out_data` and `err_illegal` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can take a request |
| in_a | input | 128 | First operand vector |
| in_b | input | 128 | Second operand vector |
| in_size | input | 2 | Element size code (width 8 << code) |
| in_cond | input | 3 | Condition code |
| in_zero_b | input | 1 | Compare each lane against zero |
| in_wide | input | 1 | 1: 128-bit register, 0: 64-bit register |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Per-lane mask result |
| err_illegal | output | 1 | One-cycle pulse after an illegal request |

## Verification
Every result, and every error pulse, is due exactly one clock edge after the edge that takes the request. The bench drives a request at a falling edge and releases it at the next falling edge. It then samples `out_valid`, `err_illegal` and `out_data` right there, half a cycle after the capturing edge. For back-pressure it holds `out_ready` low and samples at several later falling edges to confirm the held mask and the low `in_ready`. After it raises `out_ready` again, the register is due to drain at the next rising edge.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

  typedef enum logic [2:0] {
    CC_EQ   = 3'd0,
    CC_SGE  = 3'd1,
    CC_SGT  = 3'd2,
    CC_UGT  = 3'd3,
    CC_UGE  = 3'd4,
    CC_SLE  = 3'd5,
    CC_SLT  = 3'd6,
    CC_RSVD = 3'd7
  } cc_e;

  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned MAX_SIZE  = NUM_SIZES - 1;

  function automatic logic cc_supported(input logic [2:0] code);
    return code != CC_RSVD;
  endfunction

endpackage

// File: rtl/vcmp_lane.sv
module vcmp_lane
  import vcmp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  cc_e          cc,
  output logic         hit
);

  logic signed [W-1:0] sa;
  logic signed [W-1:0] sb;

  assign sa = $signed(a);
  assign sb = $signed(b);

  always_comb begin
    unique case (cc)
      CC_EQ:   hit = (a == b);
      CC_SGE:  hit = (sa >= sb);
      CC_SGT:  hit = (sa > sb);
      CC_UGT:  hit = (a > b);
      CC_UGE:  hit = (a >= b);
      CC_SLE:  hit = (sa <= sb);
      CC_SLT:  hit = (sa < sb);
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/vcmp_bank.sv
module vcmp_bank
  import vcmp_pkg::*;
#(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned SIZE   = 0
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  cc_e               cc,
  output logic [DATA_W-1:0] mask
);

  localparam int unsigned ELEM_W = 8 << SIZE;
  localparam int unsigned LANES  = DATA_W / ELEM_W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic hit;
    vcmp_lane #(.W(ELEM_W)) u_lane (
      .a   (a[k*ELEM_W +: ELEM_W]),
      .b   (b[k*ELEM_W +: ELEM_W]),
      .cc  (cc),
      .hit (hit)
    );
    assign mask[k*ELEM_W +: ELEM_W] = {ELEM_W{hit}};
  end

endmodule

// File: rtl/vec_lane_cmp.sv
module vec_lane_cmp
  import vcmp_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [1:0]        in_size,
  input  logic [2:0]        in_cond,
  input  logic              in_zero_b,
  input  logic              in_wide,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              err_illegal
);

  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] bank_mask [NUM_SIZES];
  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] next_data;
  logic              legal;
  logic              take;
  cc_e               cc;

  assign cc     = cc_e'(in_cond);
  assign opnd_b = in_zero_b ? '0 : in_b;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    vcmp_bank #(.DATA_W(DATA_W), .SIZE(s)) u_bank (
      .a    (in_a),
      .b    (opnd_b),
      .cc   (cc),
      .mask (bank_mask[s])
    );
  end

  assign keep_mask = in_wide ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  assign next_data = bank_mask[in_size] & keep_mask;

  assign legal    = cc_supported(in_cond) && !((in_size == 2'(MAX_SIZE)) && !in_wide);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      err_illegal <= 1'b0;
    end else begin
      err_illegal <= take && !legal;
      if (take) begin
        out_valid <= legal;
        if (legal) out_data <= next_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vcmp_chk.sv
module vcmp_chk #(
  parameter int unsigned DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_size,
  input logic [2:0]        in_cond,
  input logic              in_wide,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              err_illegal
);

  logic req_ok;
  assign req_ok = (in_cond != 3'd7) && !(in_size == 2'd3 && !in_wide);

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && req_ok) |=> out_valid); // R8

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && req_ok && !in_wide) |=> (out_data[DATA_W-1:DATA_W/2] == '0)); // R6

  AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !req_ok) |=> (err_illegal && !out_valid && $stable(out_data))); // R7

  AST_ERR_ONLY_AFTER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready && !req_ok) |=> !err_illegal); // R7

  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8

endmodule

bind vec_lane_cmp vcmp_chk #(.DATA_W(DATA_W)) u_vcmp_chk (.*);

// File: tb/test_vec_lane_cmp.sv
`timescale 1ns/1ps
module test_vec_lane_cmp;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready;
  logic [127:0] in_a, in_b;
  logic [1:0]   in_size;
  logic [2:0]   in_cond;
  logic         in_zero_b, in_wide;
  logic         out_valid, out_ready;
  logic [127:0] out_data;
  logic         err_illegal;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [127:0] last_exp;

  always #2.5 clk = ~clk;

  vec_lane_cmp i_vec_lane_cmp (.*);

  function automatic logic [127:0] model(input logic [127:0] a, b, input int sz,
                                         input int cc, input bit zb, input bit wide);
    logic [127:0] r = '0;
    int w = 8 << sz;
    int n = (wide ? 16 : 8) >> sz;
    for (int k = 0; k < n; k++) begin
      logic [63:0] ua = '0, ub = '0;
      logic signed [63:0] sa, sb;
      bit hit;
      for (int j = 0; j < w; j++) begin
        ua[j] = a[k*w+j];
        ub[j] = zb ? 1'b0 : b[k*w+j];
      end
      sa = ua; sb = ub;
      for (int j = w; j < 64; j++) begin
        sa[j] = ua[w-1];
        sb[j] = ub[w-1];
      end
      case (cc)
        0: hit = (ua == ub);
        1: hit = (sa >= sb);
        2: hit = (sa > sb);
        3: hit = (ua > ub);
        4: hit = (ua >= ub);
        5: hit = (sa <= sb);
        6: hit = (sa < sb);
        default: hit = 0;
      endcase
      for (int j = 0; j < w; j++) r[k*w+j] = hit;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] a, b, input int sz, input int cc,
                      input bit zb, input bit wide, input string tag);
    bit legal = (cc != 7) && !(sz == 3 && !wide);
    logic [127:0] exp = legal ? model(a, b, sz, cc, zb, wide) : last_exp;
    @(negedge clk);
    in_a = a; in_b = b; in_size = 2'(sz); in_cond = 3'(cc);
    in_zero_b = zb; in_wide = wide; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == legal, {tag, " out_valid"}, 128'(out_valid), 128'(legal));
    chk(err_illegal == !legal, {tag, " err_illegal"}, 128'(err_illegal), 128'(!legal));
    chk(out_data == exp, {tag, " out_data"}, out_data, exp);
    if (legal) last_exp = exp;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; in_valid = 0; in_a = '0; in_b = '0; in_size = 0; in_cond = 0;
    in_zero_b = 0; in_wide = 1; out_ready = 1; last_exp = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R10 out_valid", 128'(out_valid), 0);
    chk(out_data == 0, "R10 out_data", out_data, 0);
    chk(err_illegal == 0, "R10 err_illegal", 128'(err_illegal), 0);
    rst_n = 1;

    // R1/R2: equality with matching and differing lanes at every size
    for (int s = 0; s < 4; s++)
      send(128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff,
           128'h0011_2233_4455_0000_8899_aabb_ccdd_0000, s, 0, 0, 1, "R1 R2 eq");
    // R3 vs R4: 0x80 vs 0x01 is signed less, unsigned greater
    send({16{8'h80}}, {16{8'h01}}, 0, 2, 0, 1, "R3 sgt neg");
    send({16{8'h80}}, {16{8'h01}}, 0, 3, 0, 1, "R4 ugt");
    send({8{16'hffff}}, {8{16'h0000}}, 1, 6, 0, 1, "R3 slt");
    send({8{16'hffff}}, {8{16'h0000}}, 1, 4, 0, 1, "R4 uge");
    send({2{64'h8000_0000_0000_0000}}, {2{64'h7fff_ffff_ffff_ffff}}, 3, 5, 0, 1, "R3 sle 64");
    // R5: zero form ignores in_b
    send({4{32'h8000_0001}}, {128{1'b1}}, 2, 1, 1, 1, "R5 sge zero");
    send({16{8'h00}}, {16{8'h5a}}, 0, 0, 1, 1, "R5 eq zero");
    // R6: 64-bit view
    send({16{8'h7f}}, {16{8'h7f}}, 0, 0, 0, 0, "R6 narrow eq");
    send({8{16'h0001}}, '0, 1, 3, 0, 0, "R6 narrow ugt");
    // R7: illegal encodings
    send({16{8'h11}}, {16{8'h11}}, 0, 7, 0, 1, "R7 cond7");
    send({16{8'h11}}, {16{8'h11}}, 3, 0, 0, 0, "R7 size3 narrow");

    // R8/R9: back-pressure
    out_ready = 0;
    send({16{8'h33}}, {16{8'h22}}, 0, 2, 0, 1, "R8 stall take");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1, "R9 hold valid", 128'(out_valid), 1);
      chk(out_data == last_exp, "R9 hold data", out_data, last_exp);
      chk(in_ready == 0, "R8 in_ready low", 128'(in_ready), 0);
    end
    out_ready = 1;
    @(negedge clk);
    chk(out_valid == 0, "R8 drained", 128'(out_valid), 0);

    // random mix: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < 400; i++) begin
      logic [127:0] a = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] b = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 3) == 0) b = a ^ {4{$urandom & 32'h0101_0101}};
      send(a, b, $urandom_range(0, 3), $urandom_range(0, 7),
           bit'($urandom_range(0, 4) == 0), bit'($urandom_range(0, 2) != 0), "R2 R3 R4 rand");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule